// File: doc/BRIEF.md
# USB PD Transmit Token Sequencer

This block sits between a transmit byte buffer and a USB Power Delivery framing stage. Software-side logic writes a frame into the block as a stream of bytes. Most bytes are one-byte commands: ordered-set symbols, a request to insert the CRC, end of packet, and transmitter control. A length-prefix command declares that some number of the bytes after it are literal payload. The block stores the stream in an internal FIFO. It holds the frame back until the start command arrives, then replays the stored bytes as a sequence of typed symbols on a valid/ready symbol interface.

The framing stage downstream does the line coding and the CRC arithmetic. This block only decides which symbol comes next and whether a byte is a command or payload. A flush strobe discards everything that is buffered and returns the command decoding to its initial state. A sticky error flag records that a byte outside a payload run matched no known command.

Top module: `pdtx_token_seq`

## Requirements
- R1: A byte 0xA1 written outside a payload run is not stored. It releases the buffered frame: `tx_start` pulses for one cycle, once for each released frame, and no symbol is emitted for a frame whose 0xA1 has not been written.
- R2: A byte in the range 0x80 to 0x9F is a length prefix and emits no symbol. Its bits [4:0] give N, and each of the next N bytes is emitted as a data symbol (kind 0) carrying that byte, whatever its value.
- R3: Outside a payload run, the ordered-set commands map to symbol kinds as follows: 0x12 gives kind 1, 0x13 gives kind 2, 0x1B gives kind 3, 0x15 gives kind 4 and 0x16 gives kind 5.
- R4: Outside a payload run, 0xFF emits kind 6 (insert CRC) and 0x14 emits kind 7 (end of packet).
- R5: Outside a payload run, 0xFE emits kind 8 (transmitter off) and ends the frame. `busy` drops in the cycle after that symbol is accepted.
- R6: While `sym_valid` is high and `sym_ready` is low, `sym_valid`, `sym_kind` and `sym_data` hold their values.
- R7: A byte outside a payload run that is not one of the commands listed in R1 to R5 emits no symbol. It sets `err`, which stays set until reset.
- R8: A cycle with `flush` high empties the FIFO, cancels released frames and a partly sent frame, and returns both the write-side and the read-side decoding to command mode. `busy` is low in the next cycle.
- R9: A length prefix with N = 0 (0x80) leaves the following byte decoded as a command.
- R10: For an SOP frame, a writer sends three 0x12, one 0x13, a prefix whose N is 4 times the header's data-object count (header bits [14:12]) plus 2, the header low byte first, the data objects, then 0xFF, 0x14, 0xFE and 0xA1. The output is then kinds 1,1,1,2, the header bytes and payload bytes as kind 0 in the order written, then 6, 7, 8.
- R11: After reset, `busy`, `sym_valid`, `tx_start` and `err` are low and `wr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte written into the stream |
| wr_ready | output | 1 | FIFO can accept a byte |
| flush | input | 1 | Discard buffered bytes and reset decoding |
| sym_valid | output | 1 | Symbol present on the output |
| sym_kind | output | 4 | Symbol kind, encoded as in R2 to R5 |
| sym_data | output | 8 | Payload byte for kind 0 |
| sym_ready | input | 1 | Framing stage accepts the symbol |
| busy | output | 1 | Frame in progress or symbol pending |
| tx_start | output | 1 | One-cycle pulse when a frame is released |
| err | output | 1 | Sticky flag for an unknown command byte |

## Verification
On every cycle, the assertions check that a stalled symbol stays stable, that `tx_start` is a single-cycle pulse, that the error flag never clears, and that `busy` is low after a flush or after the transmitter-off symbol is accepted. They also check that a frame never completes unless it was released, and that the FIFO is empty after a flush. Only the bench scenarios can show the symbol order and the payload contents. They also show that literal bytes equal to command codes pass through untouched, that a frame stays held until its start byte, and that leftover prefix state is gone after a flush.

// File: rtl/pdtx_pkg.sv
package pdtx_pkg;

  typedef enum logic [3:0] {
    SYM_DATA  = 4'd0,
    SYM_SYNC1 = 4'd1,
    SYM_SYNC2 = 4'd2,
    SYM_SYNC3 = 4'd3,
    SYM_RST1  = 4'd4,
    SYM_RST2  = 4'd5,
    SYM_CRC   = 4'd6,
    SYM_EOP   = 4'd7,
    SYM_TXOFF = 4'd8
  } sym_kind_t;

  localparam logic [7:0] TK_SYNC1 = 8'h12;
  localparam logic [7:0] TK_SYNC2 = 8'h13;
  localparam logic [7:0] TK_SYNC3 = 8'h1B;
  localparam logic [7:0] TK_RST1  = 8'h15;
  localparam logic [7:0] TK_RST2  = 8'h16;
  localparam logic [7:0] TK_CRC   = 8'hFF;
  localparam logic [7:0] TK_EOP   = 8'h14;
  localparam logic [7:0] TK_TXOFF = 8'hFE;
  localparam logic [7:0] TK_TXON  = 8'hA1;
  localparam logic [2:0] TK_PACK_TAG = 3'b100;

  typedef struct packed {
    logic      known;
    sym_kind_t kind;
  } tok_dec_t;

  function automatic logic is_pack(input logic [7:0] b);
    return b[7:5] == TK_PACK_TAG;
  endfunction

  function automatic logic [4:0] pack_len(input logic [7:0] b);
    return b[4:0];
  endfunction

  function automatic tok_dec_t decode_token(input logic [7:0] b);
    tok_dec_t d;
    d.known = 1'b1;
    case (b)
      TK_SYNC1: d.kind = SYM_SYNC1;
      TK_SYNC2: d.kind = SYM_SYNC2;
      TK_SYNC3: d.kind = SYM_SYNC3;
      TK_RST1:  d.kind = SYM_RST1;
      TK_RST2:  d.kind = SYM_RST2;
      TK_CRC:   d.kind = SYM_CRC;
      TK_EOP:   d.kind = SYM_EOP;
      TK_TXOFF: d.kind = SYM_TXOFF;
      default: begin
        d.known = 1'b0;
        d.kind  = SYM_DATA;
      end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/pdtx_fifo.sv
module pdtx_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = DEPTH[AW:0];

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [AW:0]      count;

  logic do_wr, do_rd;
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign empty   = (count == '0);
  assign full    = (count == FULL_CNT);
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_wr && !flush) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= rd_ptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

endmodule

// File: rtl/pdtx_wr_tracker.sv
module pdtx_wr_tracker
  import pdtx_pkg::*;
#(
  parameter int PEND_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       wr_fire,
  input  logic [7:0] wr_data,
  input  logic       frame_done,
  output logic       store,
  output logic       pending_nz
);
  logic [4:0]        run_cnt;
  logic [PEND_W-1:0] pending;
  logic              txon_seen;

  assign txon_seen  = wr_fire && (run_cnt == '0) && (wr_data == TK_TXON);
  assign store      = wr_fire && !txon_seen;
  assign pending_nz = (pending != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      run_cnt <= '0;
    end else if (wr_fire) begin
      if (run_cnt != '0)          run_cnt <= run_cnt - 5'd1;
      else if (is_pack(wr_data))  run_cnt <= pack_len(wr_data);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      pending <= '0;
    end else begin
      case ({txon_seen, frame_done})
        2'b10:   pending <= pending + 1'b1;
        2'b01:   pending <= pending - 1'b1;
        default: pending <= pending;
      endcase
    end
  end

  p_done_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !flush) |-> pending_nz);

endmodule

// File: rtl/pdtx_decoder.sv
module pdtx_decoder
  import pdtx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       pending_nz,
  input  logic       fifo_empty,
  input  logic [7:0] fifo_data,
  output logic       fifo_rd,
  output logic       frame_done,
  output logic       sym_valid,
  output logic [3:0] sym_kind,
  output logic [7:0] sym_data,
  input  logic       sym_ready,
  output logic       busy,
  output logic       tx_start,
  output logic       err
);
  logic      running;
  logic [4:0] lit_cnt;
  logic      in_lit;
  logic      can_take;
  tok_dec_t  tok;
  sym_kind_t kind_q;

  assign in_lit     = (lit_cnt != '0);
  assign can_take   = running && !fifo_empty && (!sym_valid || sym_ready);
  assign fifo_rd    = can_take;
  assign tok        = decode_token(fifo_data);
  assign frame_done = can_take && !in_lit && (fifo_data == TK_TXOFF);
  assign busy       = running || sym_valid;
  assign sym_kind   = kind_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running   <= 1'b0;
      lit_cnt   <= '0;
      sym_valid <= 1'b0;
      kind_q    <= SYM_DATA;
      sym_data  <= '0;
      tx_start  <= 1'b0;
      err       <= 1'b0;
    end else if (flush) begin
      running   <= 1'b0;
      lit_cnt   <= '0;
      sym_valid <= 1'b0;
      tx_start  <= 1'b0;
    end else begin
      tx_start <= 1'b0;
      if (sym_valid && sym_ready) sym_valid <= 1'b0;
      if (!running && pending_nz && !sym_valid) begin
        running  <= 1'b1;
        tx_start <= 1'b1;
      end
      if (can_take) begin
        if (in_lit) begin
          lit_cnt   <= lit_cnt - 5'd1;
          sym_valid <= 1'b1;
          kind_q    <= SYM_DATA;
          sym_data  <= fifo_data;
        end else if (is_pack(fifo_data)) begin
          lit_cnt <= pack_len(fifo_data);
        end else if (tok.known) begin
          sym_valid <= 1'b1;
          kind_q    <= tok.kind;
          sym_data  <= fifo_data;
          if (tok.kind == SYM_TXOFF) running <= 1'b0;
        end else begin
          err <= 1'b1;
        end
      end
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && !sym_ready && !flush) |=>
      (sym_valid && $stable(sym_kind) && $stable(sym_data)));
  p_start_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  p_flush_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !busy);
  p_txoff_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_ready && sym_kind == SYM_TXOFF) |=> !busy);

endmodule

// File: rtl/pdtx_token_seq.sv
module pdtx_token_seq
  import pdtx_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  output logic       wr_ready,
  input  logic       flush,
  output logic       sym_valid,
  output logic [3:0] sym_kind,
  output logic [7:0] sym_data,
  input  logic       sym_ready,
  output logic       busy,
  output logic       tx_start,
  output logic       err
);
  localparam int AW     = $clog2(DEPTH);
  localparam int PEND_W = AW + 1;

  logic       fifo_full, fifo_empty, fifo_rd;
  logic [7:0] fifo_data;
  logic       wr_fire, store, pending_nz, frame_done;

  assign wr_ready = !fifo_full;
  assign wr_fire  = wr_valid && wr_ready;

  pdtx_wr_tracker #(.PEND_W(PEND_W)) u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .wr_fire    (wr_fire),
    .wr_data    (wr_data),
    .frame_done (frame_done),
    .store      (store),
    .pending_nz (pending_nz)
  );

  pdtx_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .wr_en   (store),
    .wr_data (wr_data),
    .rd_en   (fifo_rd),
    .rd_data (fifo_data),
    .empty   (fifo_empty),
    .full    (fifo_full)
  );

  pdtx_decoder u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .pending_nz (pending_nz),
    .fifo_empty (fifo_empty),
    .fifo_data  (fifo_data),
    .fifo_rd    (fifo_rd),
    .frame_done (frame_done),
    .sym_valid  (sym_valid),
    .sym_kind   (sym_kind),
    .sym_data   (sym_data),
    .sym_ready  (sym_ready),
    .busy       (busy),
    .tx_start   (tx_start),
    .err        (err)
  );

  p_start_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> !sym_valid);

endmodule

// File: tb/tb_pdtx_token_seq.sv
`timescale 1ns/1ps
module tb_pdtx_token_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_ready;
  logic       flush = 1'b0;
  logic       sym_valid;
  logic [3:0] sym_kind;
  logic [7:0] sym_data;
  logic       sym_ready = 1'b1;
  logic       busy, tx_start, err;

  always #2 clk = ~clk;

  pdtx_token_seq dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .flush(flush), .sym_valid(sym_valid),
    .sym_kind(sym_kind), .sym_data(sym_data), .sym_ready(sym_ready),
    .busy(busy), .tx_start(tx_start), .err(err)
  );

  int n_chk = 0;
  int n_bad = 0;
  int exp_kind [0:127];
  int exp_data [0:127];
  int n_exp = 0;
  int rx_kind [0:127];
  int rx_data [0:127];
  int n_rx = 0;
  int n_start = 0;
  bit stall = 1'b0;
  int cyc = 0;

  // Monitor: choose ready for the coming edge, then log the handshake it completes.
  always @(negedge clk) begin
    cyc = cyc + 1;
    sym_ready = stall ? ((cyc % 3) != 0) : 1'b1;
    if (rst_n && sym_valid && sym_ready && n_rx < 128) begin
      rx_kind[n_rx] = int'(sym_kind);
      rx_data[n_rx] = int'(sym_data);
      n_rx = n_rx + 1;
    end
    if (rst_n && tx_start) n_start = n_start + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    n_exp = 0; n_rx = 0; n_start = 0;
  endtask

  task automatic wr_byte(input logic [7:0] b);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = b;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic want(input int k, input int d);
    exp_kind[n_exp] = k; exp_data[n_exp] = d; n_exp++;
  endtask

  task automatic wait_idle();
    repeat (4) @(negedge clk);
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic compare(input string req, input int starts);
    chk(n_rx == n_exp, req, n_rx, n_exp);
    for (int i = 0; i < n_exp && i < n_rx; i++) begin
      chk(rx_kind[i] == exp_kind[i], req, rx_kind[i], exp_kind[i]);
      if (exp_kind[i] == 0) chk(rx_data[i] == exp_data[i], req, rx_data[i], exp_data[i]);
    end
    chk(n_start == starts, req, n_start, starts);
    chk(!busy && !sym_valid, req, int'(busy), 0);
  endtask

  // Writes an SOP frame without its start byte; payload count from header (R10).
  task automatic sop_body(input logic [15:0] hdr, input logic [7:0] seed);
    int ndo = int'(hdr[14:12]);
    int len = ndo * 4 + 2;
    for (int i = 0; i < 3; i++) begin wr_byte(8'h12); want(1, 0); end
    wr_byte(8'h13); want(2, 0);
    wr_byte(8'h80 | 8'(len));
    wr_byte(hdr[7:0]);  want(0, int'(hdr[7:0]));
    wr_byte(hdr[15:8]); want(0, int'(hdr[15:8]));
    for (int i = 0; i < ndo * 4; i++) begin
      logic [7:0] b = seed + 8'(i * 37);
      if (i == 0) b = 8'hA1;
      if (i == 1) b = 8'h12;
      if (i == 2) b = 8'hFE;
      if (i == 3) b = 8'h80;
      if (i == 4) b = 8'hFF;
      wr_byte(b); want(0, int'(b));
    end
    wr_byte(8'hFF); want(6, 0);
    wr_byte(8'h14); want(7, 0);
    wr_byte(8'hFE); want(8, 0);
  endtask

  task automatic t_reset();
    chk(!busy, "R11 busy", int'(busy), 0);
    chk(!sym_valid, "R11 sym_valid", int'(sym_valid), 0);
    chk(!tx_start, "R11 tx_start", int'(tx_start), 0);
    chk(!err, "R11 err", int'(err), 0);
    chk(wr_ready, "R11 wr_ready", int'(wr_ready), 1);
  endtask

  task automatic t_sop_header_only();
    clear_log();
    sop_body(16'h0041, 8'h00);
    wr_byte(8'hA1);
    wait_idle();
    compare("R10 header-only SOP", 1);
    chk(!err, "R7 no error on clean frame", int'(err), 0);
  endtask

  task automatic t_literal_stall();
    clear_log();
    stall = 1'b1;
    sop_body(16'h2161, 8'h3C);
    wr_byte(8'hA1);
    wait_idle();
    compare("R2 R6 literal payload with stalls", 1);
    stall = 1'b0;
  endtask

  task automatic t_holdoff();
    clear_log();
    wr_byte(8'h12); want(1, 0);
    wr_byte(8'h14); want(7, 0);
    wr_byte(8'hFE); want(8, 0);
    repeat (30) @(negedge clk);
    chk(n_rx == 0, "R1 held before start byte", n_rx, 0);
    chk(!busy, "R1 idle before start byte", int'(busy), 0);
    chk(n_start == 0, "R1 no start pulse", n_start, 0);
    wr_byte(8'hA1);
    wait_idle();
    compare("R1 R4 R5 released frame", 1);
  endtask

  task automatic t_ordered_sets();
    clear_log();
    for (int i = 0; i < 3; i++) begin wr_byte(8'h15); want(4, 0); end
    wr_byte(8'h16); want(5, 0);
    wr_byte(8'h1B); want(3, 0);
    wr_byte(8'h13); want(2, 0);
    wr_byte(8'hFE); want(8, 0);
    wr_byte(8'hA1);
    wait_idle();
    compare("R3 ordered-set kinds", 1);
  endtask

  task automatic t_zero_pack();
    clear_log();
    wr_byte(8'h12); want(1, 0);
    wr_byte(8'h80);
    wr_byte(8'h14); want(7, 0);
    wr_byte(8'hFE); want(8, 0);
    wr_byte(8'hA1);
    wait_idle();
    compare("R9 zero-length prefix", 1);
  endtask

  task automatic t_two_frames();
    clear_log();
    wr_byte(8'h12); want(1, 0);
    wr_byte(8'hFE); want(8, 0);
    wr_byte(8'hA1);
    wr_byte(8'h81);
    wr_byte(8'hA1); want(0, 8'hA1);
    wr_byte(8'hFF); want(6, 0);
    wr_byte(8'hFE); want(8, 0);
    wr_byte(8'hA1);
    wait_idle();
    compare("R1 R2 two released frames", 2);
  endtask

  task automatic t_flush();
    clear_log();
    wr_byte(8'h12);
    wr_byte(8'h85);
    wr_byte(8'h11);
    wr_byte(8'h22);
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    chk(!busy, "R8 idle after flush", int'(busy), 0);
    wr_byte(8'h12); want(1, 0);
    wr_byte(8'h13); want(2, 0);
    wr_byte(8'h82);
    wr_byte(8'hAA); want(0, 8'hAA);
    wr_byte(8'hBB); want(0, 8'hBB);
    wr_byte(8'h14); want(7, 0);
    wr_byte(8'hFE); want(8, 0);
    wr_byte(8'hA1);
    wait_idle();
    compare("R8 clean frame after flush", 1);
  endtask

  task automatic t_unknown();
    clear_log();
    chk(!err, "R7 err low before unknown byte", int'(err), 0);
    wr_byte(8'h12); want(1, 0);
    wr_byte(8'h55);
    wr_byte(8'h00);
    wr_byte(8'h13); want(2, 0);
    wr_byte(8'hFE); want(8, 0);
    wr_byte(8'hA1);
    wait_idle();
    compare("R7 unknown bytes dropped", 1);
    chk(err, "R7 err set", int'(err), 1);
    clear_log();
    wr_byte(8'h14); want(7, 0);
    wr_byte(8'hFE); want(8, 0);
    wr_byte(8'hA1);
    wait_idle();
    compare("R7 later frame", 1);
    chk(err, "R7 err sticky", int'(err), 1);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sop_header_only();
    t_literal_stall();
    t_holdoff();
    t_ordered_sets();
    t_zero_pack();
    t_two_frames();
    t_flush();
    t_unknown();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    summary();
  end

endmodule